// File: doc/BRIEF.md
# Interrupt Source Routing Table

This block keeps one 64-bit routing word for every interrupt source. Source number N owns word N: no base is subtracted before the lookup. Each word says four things. It says whether the source is in use, whether it is silenced, which destination queue (block and index) takes its events, and what 31-bit value is posted into that queue.

A configuration port can read a word, write a whole word, or turn the in-use flag of one source on or off. Every configuration request gets a one-cycle acknowledge with a success bit.

A notify input takes an interrupt number, much like a source storing its number to a notify address. One clock later the block gives exactly one of two results. It either pulses a routed event carrying the queue block, queue index and queue data, or it pulses a dropped flag.

Reset does not wipe the table. While reset is held, every word that is in use has its silence flag set, and nothing else changes.

Top module: `src_route_table`

## Requirements
- R1: Every word powers up as all zeros, so after the first reset a read of any in-range source returns 0 and a notify for it is dropped.
- R2: Word bits are numbered from the most significant end, so layout bit k sits at vector bit 63-k. The fields are: in-use flag at bit 0, queue block at bits 4-7, queue index at bits 8-31, silence flag at bit 32, and queue data at bits 33-63. A routed event carries these three fields unchanged.
- R3: A notify for a source whose word is in use but silenced produces no routed event and a one-cycle dropped pulse.
- R4: A notify for a source whose word is not in use produces no routed event and a one-cycle dropped pulse.
- R5: A configuration request or notify with a number at or above NUM_SRC changes no word. A configuration request acknowledges with success 0 and read data 0, and a notify is dropped.
- R6: The opcode enable (2) sets only the in-use flag of the addressed word, and disable (3) clears only that flag. Both acknowledge with success 1 when the number is in range.
- R7: While reset is held, every word with the in-use flag set gets its silence flag set. All other bits, and words not in use, keep their contents.
- R8: Routed and dropped outputs pulse in the clock cycle after the notify cycle. Routed and dropped are never high together. A new notify can be given on every cycle.
- R9: A full write (opcode 1) and a notify to the same source in the same cycle route the event with the word as it stood before the write.
- R10: Every configuration request is acknowledged on the next cycle. A read (opcode 0) returns the stored word, and the other opcodes return read data 0.
- R11: The queue block, index and data outputs are zero whenever the routed pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also runs the silencing sweep |
| cfgValid | input | 1 | Configuration request strobe |
| cfgOp | input | 2 | 0 read, 1 write, 2 enable, 3 disable |
| cfgNum | input | NUM_W | Source number addressed by the request |
| cfgWdata | input | 64 | Full word for a write |
| cfgDone | output | 1 | Request acknowledge, one cycle after the request |
| cfgOk | output | 1 | Request succeeded (number in range) |
| cfgRdata | output | 64 | Word returned by a read |
| notifyValid | input | 1 | Notify strobe |
| notifyNum | input | NUM_W | Interrupt number being notified |
| routeValid | output | 1 | Routed event pulse |
| routeBlock | output | 4 | Destination queue block |
| routeIndex | output | 24 | Destination queue index |
| routeData | output | 31 | Data to post into the queue |
| dropValid | output | 1 | Notify was not forwarded |

## Verification
A corrupted word, such as a stuck in-use or silence flag or a shifted field, shows up one clock after the next notify for that source. It appears as a routed pulse where a drop was due, a drop where a route was due, or wrong queue fields. A read of the same source shows it on the acknowledge cycle. An index that aliases out-of-range numbers onto real words shows up only on a later read or notify of the aliased source. The bench therefore re-reads a known word after each out-of-range attempt. A reset sweep that touches the wrong bits shows up on the first read after reset is released.

// File: rtl/src_route_pkg.sv
package src_route_pkg;

  // Vector positions of the word fields (layout bit k is vector bit 63-k)
  localparam int VALID_BIT  = 63;
  localparam int BLOCK_HI   = 59;
  localparam int BLOCK_LO   = 56;
  localparam int INDEX_HI   = 55;
  localparam int INDEX_LO   = 32;
  localparam int MASK_BIT   = 31;
  localparam int DATA_HI    = 30;
  localparam int DATA_LO    = 0;

  typedef enum logic [1:0] {
    CFG_READ    = 2'd0,
    CFG_WRITE   = 2'd1,
    CFG_ENABLE  = 2'd2,
    CFG_DISABLE = 2'd3
  } cfgOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic tblWrite;
    logic setValid;
    logic clrValid;
    logic cfgRead;
    logic cfgAck;
    logic cfgOkNext;
    logic evtLook;
    logic evtInRange;
  } ctrlStrobe_t;

endpackage

// File: rtl/src_route_ctrl.sv
module src_route_ctrl
  import src_route_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_W   = 16
) (
  input  logic             cfgValid,
  input  logic [1:0]       cfgOp,
  input  logic [NUM_W-1:0] cfgNum,
  input  logic             notifyValid,
  input  logic [NUM_W-1:0] notifyNum,
  output ctrlStrobe_t      strobe
);

  localparam logic [NUM_W:0] LIMIT = (NUM_W+1)'(NUM_SRC);

  logic cfgInRange;
  logic notifyInRange;
  cfgOp_e opCode;

  assign cfgInRange    = {1'b0, cfgNum} < LIMIT;
  assign notifyInRange = {1'b0, notifyNum} < LIMIT;
  assign opCode        = cfgOp_e'(cfgOp);

  always_comb begin
    strobe            = '0;
    strobe.cfgAck     = cfgValid;
    strobe.cfgOkNext  = cfgValid && cfgInRange;
    strobe.evtLook    = notifyValid;
    strobe.evtInRange = notifyValid && notifyInRange;
    if (cfgValid && cfgInRange) begin
      unique case (opCode)
        CFG_READ:    strobe.cfgRead  = 1'b1;
        CFG_WRITE:   strobe.tblWrite = 1'b1;
        CFG_ENABLE:  strobe.setValid = 1'b1;
        CFG_DISABLE: strobe.clrValid = 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/src_route_dpath.sv
module src_route_dpath
  import src_route_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [63:0]      cfgWdata,
  input  logic [IDX_W-1:0] evtIdx,
  output logic             cfgDone,
  output logic             cfgOk,
  output logic [63:0]      cfgRdata,
  output logic             routeValid,
  output logic [3:0]       routeBlock,
  output logic [23:0]      routeIndex,
  output logic [30:0]      routeData,
  output logic             dropValid
);

  logic [63:0] entry [NUM_SRC] = '{default: '0};
  logic [63:0] cfgEntry;
  logic [63:0] evtEntry;
  logic        evtHit;

  // Table update: reset silences in-use words, otherwise one config action
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!rst_n) begin
        if (entry[i][VALID_BIT]) entry[i][MASK_BIT] <= 1'b1;
      end else if (cfgIdx == IDX_W'(i)) begin
        if (strobe.tblWrite)      entry[i] <= cfgWdata;
        else if (strobe.setValid) entry[i][VALID_BIT] <= 1'b1;
        else if (strobe.clrValid) entry[i][VALID_BIT] <= 1'b0;
      end
    end
  end

  assign cfgEntry = strobe.cfgRead ? entry[cfgIdx] : 64'd0;
  assign evtEntry = strobe.evtInRange ? entry[evtIdx] : 64'd0;
  assign evtHit   = strobe.evtInRange && evtEntry[VALID_BIT] && !evtEntry[MASK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgDone    <= 1'b0;
      cfgOk      <= 1'b0;
      cfgRdata   <= '0;
      routeValid <= 1'b0;
      routeBlock <= '0;
      routeIndex <= '0;
      routeData  <= '0;
      dropValid  <= 1'b0;
    end else begin
      cfgDone    <= strobe.cfgAck;
      cfgOk      <= strobe.cfgOkNext;
      cfgRdata   <= cfgEntry;
      routeValid <= evtHit;
      dropValid  <= strobe.evtLook && !evtHit;
      routeBlock <= evtHit ? evtEntry[BLOCK_HI:BLOCK_LO] : '0;
      routeIndex <= evtHit ? evtEntry[INDEX_HI:INDEX_LO] : '0;
      routeData  <= evtHit ? evtEntry[DATA_HI:DATA_LO]   : '0;
    end
  end

endmodule

// File: rtl/src_route_table.sv
module src_route_table
  import src_route_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgValid,
  input  logic [1:0]       cfgOp,
  input  logic [NUM_W-1:0] cfgNum,
  input  logic [63:0]      cfgWdata,
  output logic             cfgDone,
  output logic             cfgOk,
  output logic [63:0]      cfgRdata,
  input  logic             notifyValid,
  input  logic [NUM_W-1:0] notifyNum,
  output logic             routeValid,
  output logic [3:0]       routeBlock,
  output logic [23:0]      routeIndex,
  output logic [30:0]      routeData,
  output logic             dropValid
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ctrlStrobe_t strobe;

  src_route_ctrl #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W)) u_ctrl (
    .cfgValid    (cfgValid),
    .cfgOp       (cfgOp),
    .cfgNum      (cfgNum),
    .notifyValid (notifyValid),
    .notifyNum   (notifyNum),
    .strobe      (strobe)
  );

  src_route_dpath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .cfgIdx     (cfgNum[IDX_W-1:0]),
    .cfgWdata   (cfgWdata),
    .evtIdx     (notifyNum[IDX_W-1:0]),
    .cfgDone    (cfgDone),
    .cfgOk      (cfgOk),
    .cfgRdata   (cfgRdata),
    .routeValid (routeValid),
    .routeBlock (routeBlock),
    .routeIndex (routeIndex),
    .routeData  (routeData),
    .dropValid  (dropValid)
  );

endmodule

// File: rtl/src_route_checker.sv
module src_route_checker #(
  parameter int NUM_SRC = 16,
  parameter int NUM_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfgValid,
  input logic [1:0]       cfgOp,
  input logic [NUM_W-1:0] cfgNum,
  input logic [63:0]      cfgWdata,
  input logic             cfgDone,
  input logic             cfgOk,
  input logic [63:0]      cfgRdata,
  input logic             notifyValid,
  input logic [NUM_W-1:0] notifyNum,
  input logic             routeValid,
  input logic [3:0]       routeBlock,
  input logic [23:0]      routeIndex,
  input logic [30:0]      routeData,
  input logic             dropValid
);

  localparam logic [NUM_W:0] LIMIT = (NUM_W+1)'(NUM_SRC);

  assert_route_drop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(routeValid && dropValid));

  assert_notify_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    notifyValid |=> (routeValid || dropValid));

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !notifyValid |=> (!routeValid && !dropValid));

  assert_oor_notify_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (notifyValid && ({1'b0, notifyNum} >= LIMIT)) |=> dropValid);

  assert_oor_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgValid && ({1'b0, cfgNum} >= LIMIT)) |=> (cfgDone && !cfgOk && cfgRdata == 64'd0));

  assert_cfg_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfgValid |=> cfgDone);

  assert_idle_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !routeValid |-> (routeBlock == 4'd0 && routeIndex == 24'd0 && routeData == 31'd0));

endmodule

bind src_route_table src_route_checker #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W)) u_chk (.*);

// File: tb/test_src_route_table.sv
module test_src_route_table;

  localparam int NUM_SRC = 16;
  localparam int NUM_W   = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfgValid = 1'b0;
  logic [1:0]       cfgOp = 2'd0;
  logic [NUM_W-1:0] cfgNum = '0;
  logic [63:0]      cfgWdata = '0;
  logic             cfgDone;
  logic             cfgOk;
  logic [63:0]      cfgRdata;
  logic             notifyValid = 1'b0;
  logic [NUM_W-1:0] notifyNum = '0;
  logic             routeValid;
  logic [3:0]       routeBlock;
  logic [23:0]      routeIndex;
  logic [30:0]      routeData;
  logic             dropValid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  src_route_table #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W)) i_src_route_table (.*);

  // Word layout from R2: valid@63, block@59:56, index@55:32, mask@31, data@30:0
  function automatic logic [63:0] mk(input logic v, input logic [3:0] blk,
                                     input logic [23:0] idx, input logic m,
                                     input logic [30:0] dat);
    return {v, 3'b000, blk, idx, m, dat};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doCfg(input logic [1:0] op, input logic [NUM_W-1:0] num, input logic [63:0] w);
    @(negedge clk);
    cfgValid = 1'b1; cfgOp = op; cfgNum = num; cfgWdata = w;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  task automatic chkCfg(input string req, input logic ok, input logic [63:0] rd);
    chk({req, " done"}, {63'd0, cfgDone}, 64'd1);
    chk({req, " ok"}, {63'd0, cfgOk}, {63'd0, ok});
    chk({req, " rdata"}, cfgRdata, rd);
  endtask

  task automatic doNotify(input logic [NUM_W-1:0] num);
    @(negedge clk);
    notifyValid = 1'b1; notifyNum = num;
    @(negedge clk);
    notifyValid = 1'b0;
  endtask

  task automatic chkRoute(input string req, input logic rv, input logic dv,
                          input logic [63:0] ent);
    logic [63:0] expF;
    expF = rv ? {4'd0, ent[59:56], ent[55:32], 1'b0, ent[30:0]} : 64'd0;
    chk({req, " route"}, {63'd0, routeValid}, {63'd0, rv});
    chk({req, " drop"}, {63'd0, dropValid}, {63'd0, dv});
    chk({req, " fields"}, {4'd0, routeBlock, routeIndex, 1'b0, routeData}, expF);
  endtask

  localparam logic [63:0] E5 = 64'h0;

  task automatic testReset();
    chk("R11 reset route idle", {62'd0, routeValid, dropValid}, 64'd0);
    doCfg(2'd0, 16'd3, 64'd0);
    chkCfg("R1 powerup read", 1'b1, 64'd0);
    doNotify(16'd3);
    chkRoute("R1 powerup notify", 1'b0, 1'b1, 64'd0);
  endtask

  task automatic testRoute();
    logic [63:0] e;
    e = mk(1'b1, 4'hA, 24'h123456, 1'b0, 31'h1BCDEF01);
    doCfg(2'd1, 16'd5, e);
    chkCfg("R10 write ack", 1'b1, 64'd0);
    doCfg(2'd0, 16'd5, 64'd0);
    chkCfg("R10 readback", 1'b1, e);
    doNotify(16'd5);
    chkRoute("R2 routed fields", 1'b1, 1'b0, e);
    e = mk(1'b1, 4'h3, 24'hFFFFFF, 1'b0, 31'h7FFFFFFF);
    doCfg(2'd1, 16'd15, e);
    doNotify(16'd15);
    chkRoute("R2 top entry all ones", 1'b1, 1'b0, e);
  endtask

  task automatic testMasked();
    doCfg(2'd1, 16'd6, mk(1'b1, 4'h2, 24'h000777, 1'b1, 31'h55));
    doNotify(16'd6);
    chkRoute("R3 masked", 1'b0, 1'b1, 64'd0);
  endtask

  task automatic testEnable();
    logic [63:0] e;
    e = mk(1'b0, 4'h7, 24'h00ABCD, 1'b0, 31'h00001234);
    doCfg(2'd1, 16'd7, e);
    doNotify(16'd7);
    chkRoute("R4 not in use", 1'b0, 1'b1, 64'd0);
    doCfg(2'd2, 16'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    chkCfg("R6 enable ack", 1'b1, 64'd0);
    doCfg(2'd0, 16'd7, 64'd0);
    chkCfg("R6 enable only valid", 1'b1, e | 64'h8000_0000_0000_0000);
    doNotify(16'd7);
    chkRoute("R6 enabled routes", 1'b1, 1'b0, e);
    doCfg(2'd3, 16'd7, 64'd0);
    chkCfg("R6 disable ack", 1'b1, 64'd0);
    doCfg(2'd0, 16'd7, 64'd0);
    chkCfg("R6 disable only valid", 1'b1, e);
    doNotify(16'd7);
    chkRoute("R4 disabled drops", 1'b0, 1'b1, 64'd0);
  endtask

  task automatic testRange();
    logic [63:0] e0;
    e0 = mk(1'b1, 4'h1, 24'h000010, 1'b0, 31'h10);
    doCfg(2'd1, 16'd0, e0);
    doCfg(2'd1, 16'd16, mk(1'b1, 4'hF, 24'h1, 1'b1, 31'h1));
    chkCfg("R5 write oor", 1'b0, 64'd0);
    doCfg(2'd3, 16'd16, 64'd0);
    chkCfg("R5 disable oor", 1'b0, 64'd0);
    doCfg(2'd2, 16'hFFFF, 64'd0);
    chkCfg("R5 enable oor", 1'b0, 64'd0);
    doCfg(2'd0, 16'd16, 64'd0);
    chkCfg("R5 read oor", 1'b0, 64'd0);
    doCfg(2'd0, 16'd0, 64'd0);
    chkCfg("R5 entry0 untouched", 1'b1, e0);
    doNotify(16'd16);
    chkRoute("R5 notify oor", 1'b0, 1'b1, 64'd0);
  endtask

  task automatic testBackToBack();
    logic [63:0] e5;
    doCfg(2'd0, 16'd5, 64'd0);
    e5 = cfgRdata;
    @(negedge clk); notifyValid = 1'b1; notifyNum = 16'd5;
    @(negedge clk); notifyNum = 16'd6;
    chkRoute("R8 b2b first", 1'b1, 1'b0, e5);
    @(negedge clk); notifyNum = 16'd5;
    chkRoute("R8 b2b second", 1'b0, 1'b1, 64'd0);
    @(negedge clk); notifyValid = 1'b0;
    chkRoute("R8 b2b third", 1'b1, 1'b0, e5);
    @(negedge clk);
    chkRoute("R8 idle after", 1'b0, 1'b0, 64'd0);
  endtask

  task automatic testSameCycle();
    logic [63:0] oldE;
    oldE = mk(1'b1, 4'hA, 24'h123456, 1'b0, 31'h1BCDEF01);
    @(negedge clk);
    cfgValid = 1'b1; cfgOp = 2'd1; cfgNum = 16'd5;
    cfgWdata = mk(1'b1, 4'h4, 24'h000001, 1'b1, 31'h2);
    notifyValid = 1'b1; notifyNum = 16'd5;
    @(negedge clk);
    cfgValid = 1'b0; notifyValid = 1'b0;
    chkRoute("R9 old word used", 1'b1, 1'b0, oldE);
    doNotify(16'd5);
    chkRoute("R9 new word applies", 1'b0, 1'b1, 64'd0);
  endtask

  task automatic testSweep();
    logic [63:0] e8, e9;
    e8 = mk(1'b1, 4'h8, 24'h000888, 1'b0, 31'h888);
    e9 = mk(1'b0, 4'h9, 24'h000999, 1'b0, 31'h999);
    doCfg(2'd1, 16'd8, e8);
    doCfg(2'd1, 16'd9, e9);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    doCfg(2'd0, 16'd8, 64'd0);
    chkCfg("R7 in-use word masked", 1'b1, e8 | 64'h0000_0000_8000_0000);
    doCfg(2'd0, 16'd9, 64'd0);
    chkCfg("R7 unused word kept", 1'b1, e9);
    doNotify(16'd8);
    chkRoute("R7 swept source drops", 1'b0, 1'b1, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testRoute();
    testMasked();
    testEnable();
    testRange();
    testBackToBack();
    testSameCycle();
    testSweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule